// File: doc/BRIEF.md
# Centred Three-Phase Space-Vector PWM Timer

This block produces three centre-aligned leg drive signals. They are computed straight from three signed instantaneous phase references, with no sector table and no angle arithmetic. Each switching period, the block scales every reference into a signed per-phase time. It then finds the largest and smallest of these times. The spread between them is the active duration, and the rest of the period is zero-vector time. A common offset shifts all three times so that this zero time is split evenly between the two ends of the period. The shifted times are compared against a triangular up/down period counter, so each leg pulse sits symmetrically around the middle of the period.

The block also reports, as a one-hot flag set, which phase reference currently lies between the other two. A downstream vector-selection stage can use this flag. The period length is given as a half-period count H, so the period is always 2H clocks. A start strobe begins continuous, back-to-back periods. References and H are taken in only at the clock edge that begins a period, so a period already in progress is never disturbed.

Top module: `svpwm_centered`

## Requirements
- R1: After reset, and until a start strobe is accepted, all three leg outputs and all three middle flags are low; reset at any time returns the block to this idle state.
- R2: A start strobe seen while idle begins a period at that clock edge. Periods then repeat back to back, each 2·H clocks long, where H (≥ 1) is the half-period input taken at that period's first edge. A start strobe seen while running has no effect.
- R3: The references and H are sampled only at the edge that begins a period. Changes at any other time do not affect the current period's legs or flags.
- R4: Each reference V (two's complement, REF_W bits, with 2^(REF_W−1) standing for the full dc-link voltage) becomes the phase time T = floor(V·2H / 2^(REF_W−1)).
- R5: With Tmax and Tmin the largest and smallest phase times, Teff = Tmax − Tmin, T0 = 2H − Teff and offset = floor(T0/2) − Tmin. Each shifted time is S = T + offset, and each leg is high for 2·floor(S/2) clocks of the period.
- R6: Number the clocks of a period j = 0 … 2H−1 and define c(j) = j for j < H and c(j) = 2H−1−j otherwise. A leg with half-width w = floor(S/2) is high exactly when c(j) ≥ H − w, so its pulse is centred in the period.
- R7: In overmodulation, Teff is limited to 2H (which leaves no zero time), and each shifted time is limited to the range 0 … 2H.
- R8: While running, exactly one middle flag is high: bit mid_a for phase A, mid_b for B, mid_c for C. It marks the phase whose reference lies between the other two references.
- R9: When references are equal, the middle flag goes to the first phase, in the order A, B, C, that lies between the other two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that starts continuous operation |
| half_period | input | CNT_W | Half-period count H; period is 2H clocks |
| ref_a | input | REF_W | Signed phase A reference |
| ref_b | input | REF_W | Signed phase B reference |
| ref_c | input | REF_W | Signed phase C reference |
| leg_a | output | 1 | Phase A leg drive |
| leg_b | output | 1 | Phase B leg drive |
| leg_c | output | 1 | Phase C leg drive |
| mid_a | output | 1 | Phase A holds the middle reference |
| mid_b | output | 1 | Phase B holds the middle reference |
| mid_c | output | 1 | Phase C holds the middle reference |

## Verification
The bench applies references that overmodulate. If the clamp were missing, shifted times would exceed the period and legs would wrap or stay low instead of saturating high. It applies equal references in several arrangements, which exposes a tie rule that picks no flag, two flags or the wrong phase. In the middle of each period it changes the references and H and pulses start again, so a design that samples outside the boundary or restarts shows a skewed or truncated pulse. It changes H from one period to the next and drives full-scale negative references. Either exposes an off-by-one in the triangle counter, or an offset that uses Tmax in place of Tmin, as a pulse shifted away from the centre.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

    localparam int NPH = 3;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    typedef struct packed {
        logic c;
        logic b;
        logic a;
    } tri_flags_t;

    // Keep only the lowest set candidate: A wins over B, B over C.
    function automatic tri_flags_t first_candidate(input logic [NPH-1:0] cand);
        tri_flags_t f;
        f = '0;
        if (cand[PH_A])      f.a = 1'b1;
        else if (cand[PH_B]) f.b = 1'b1;
        else                 f.c = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/svpwm_period_ctr.sv
module svpwm_period_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] half_period,
    output logic             running,
    output logic             load,
    output logic [CNT_W:0]   k,
    output logic [CNT_W-1:0] hq,
    output logic [CNT_W-1:0] tri_cnt
);
    localparam int KW = CNT_W + 1;

    logic [KW-1:0] last;

    assign last    = {hq, 1'b0} - KW'(1);
    assign load    = (start && !running) || (running && (k == last));
    assign tri_cnt = (k < {1'b0, hq}) ? CNT_W'(k) : CNT_W'(last - k);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            k       <= '0;
            hq      <= '0;
        end else if (load) begin
            running <= 1'b1;
            k       <= '0;
            hq      <= half_period;
        end else if (running) begin
            k <= k + KW'(1);
        end
    end

    // R2: position never leaves the current period
    p_k_in_period_r2: assert property (@(posedge clk) disable iff (rst)
        running |-> ({1'b0, k} < {1'b0, hq, 1'b0}));

    // R2: inside a period the position advances by one each clock
    p_k_steps_r2: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && (k != '0)) |-> (k == $past(k) + KW'(1)));

endmodule

// File: rtl/svpwm_phase_times.sv
module svpwm_phase_times
    import svpwm_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int CNT_W = 10
) (
    input  logic                    [CNT_W-1:0] half_period,
    input  logic signed             [REF_W-1:0] ref_a,
    input  logic signed             [REF_W-1:0] ref_b,
    input  logic signed             [REF_W-1:0] ref_c,
    output logic [NPH-1:0][CNT_W-1:0]           thr,
    output tri_flags_t                          mid
);
    localparam int TW = CNT_W + 3;
    localparam int PW = REF_W + CNT_W + 2;

    logic signed [REF_W-1:0] refs [NPH];
    logic signed [TW-1:0]    t    [NPH];
    logic signed [TW-1:0]    s    [NPH];
    logic signed [TW-1:0]    ts, tmax, tmin, teff, t0, offs;
    logic        [NPH-1:0]   between;

    assign refs[0] = ref_a;
    assign refs[1] = ref_b;
    assign refs[2] = ref_c;
    assign ts      = TW'({half_period, 1'b0});

    // R4: scale every reference to a signed time
    for (genvar i = 0; i < NPH; i++) begin : g_scale
        logic signed [PW-1:0] prod;
        assign prod = PW'(refs[i]) * PW'($signed({1'b0, half_period, 1'b0}));
        assign t[i] = TW'(prod >>> (REF_W - 1));
    end

    always_comb begin
        tmax = t[0];
        tmin = t[0];
        for (int i = 1; i < NPH; i++) begin
            if (t[i] > tmax) tmax = t[i];
            if (t[i] < tmin) tmin = t[i];
        end
        teff = tmax - tmin;
        if (teff > ts) teff = ts;          // R7: drop zero time
        t0   = ts - teff;
        offs = (t0 >>> 1) - tmin;          // R5: centring offset
    end

    for (genvar i = 0; i < NPH; i++) begin : g_shift
        logic signed [TW-1:0] raw;
        assign raw = t[i] + offs;
        always_comb begin
            if (raw < 0)       s[i] = '0;
            else if (raw > ts) s[i] = ts;
            else               s[i] = raw;
        end
        assign thr[i] = half_period - CNT_W'(s[i] >>> 1);
    end

    // R8/R9: middle-phase candidates taken from the references
    for (genvar i = 0; i < NPH; i++) begin : g_mid
        localparam int J = (i + 1) % NPH;
        localparam int L = (i + 2) % NPH;
        assign between[i] = ((refs[i] >= refs[J]) && (refs[i] <= refs[L])) ||
                            ((refs[i] <= refs[J]) && (refs[i] >= refs[L]));
    end

    assign mid = first_candidate(between);

endmodule

// File: rtl/svpwm_centered.sv
module svpwm_centered
    import svpwm_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int CNT_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [CNT_W-1:0]        half_period,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    output logic                    leg_a,
    output logic                    leg_b,
    output logic                    leg_c,
    output logic                    mid_a,
    output logic                    mid_b,
    output logic                    mid_c
);
    logic                        running, load;
    logic [CNT_W:0]              k;
    logic [CNT_W-1:0]            hq, tri_cnt;
    logic [NPH-1:0][CNT_W-1:0]   thr_n, thr_q;
    tri_flags_t                  mid_n, mid_q;
    logic [NPH-1:0]              legs;

    svpwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .half_period (half_period),
        .running     (running),
        .load        (load),
        .k           (k),
        .hq          (hq),
        .tri_cnt     (tri_cnt)
    );

    svpwm_phase_times #(.REF_W(REF_W), .CNT_W(CNT_W)) u_times (
        .half_period (half_period),
        .ref_a       (ref_a),
        .ref_b       (ref_b),
        .ref_c       (ref_c),
        .thr         (thr_n),
        .mid         (mid_n)
    );

    // R3: thresholds and flags change only at a period boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
            mid_q <= '0;
        end else if (load) begin
            thr_q <= thr_n;
            mid_q <= mid_n;
        end
    end

    // R6: leg high while the triangle sits at or above its threshold
    for (genvar i = 0; i < NPH; i++) begin : g_leg
        assign legs[i] = running && (tri_cnt >= thr_q[i]);
    end

    assign leg_a = legs[PH_A];
    assign leg_b = legs[PH_B];
    assign leg_c = legs[PH_C];
    assign mid_a = mid_q.a;
    assign mid_b = mid_q.b;
    assign mid_c = mid_q.c;

    p_mid_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        running |-> $onehot({mid_c, mid_b, mid_a}));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !running |-> ({leg_a, leg_b, leg_c, mid_a, mid_b, mid_c} == 6'b0));

    p_thr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && (k != '0)) |-> ($stable(thr_q) && $stable(mid_q)));

    p_rise_first_half_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(leg_a) || $rose(leg_b) || $rose(leg_c)) |-> ({1'b0, k} < {2'b0, hq}));

endmodule

// File: tb/test_svpwm_centered.sv
module test_svpwm_centered;
    localparam int CLK_PERIOD = 10;
    localparam int REF_W = 12;
    localparam int CNT_W = 10;
    localparam int NV = 8;

    localparam int VH [NV] = '{50, 50, 50, 50, 50, 20, 64, 50};
    localparam int VA [NV] = '{512, 0, 2047, 300, -500, -1000, 1500, -2048};
    localparam int VB [NV] = '{-256, 0, -2048, -100, 100, 700, -1500, -2048};
    localparam int VC [NV] = '{-256, 0, 0, 300, 100, 200, 1000, -2048};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CNT_W-1:0] half_period = '0;
    logic signed [REF_W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
    logic leg_a, leg_b, leg_c, mid_a, mid_b, mid_c;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svpwm_centered #(.REF_W(REF_W), .CNT_W(CNT_W)) i_svpwm_centered (
        .clk(clk), .rst(rst), .start(start), .half_period(half_period),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .leg_a(leg_a), .leg_b(leg_b), .leg_c(leg_c),
        .mid_a(mid_a), .mid_b(mid_b), .mid_c(mid_c)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R4: phase time from reference
    function automatic int ptime(input int h, input int v);
        return (v * 2 * h) >>> (REF_W - 1);
    endfunction

    // R5/R7: half-width of the centred pulse for phase p
    function automatic int half_w(input int h, input int a, input int b, input int c, input int p);
        int t [3];
        int mx, mn, teff, t0, s;
        t[0] = ptime(h, a); t[1] = ptime(h, b); t[2] = ptime(h, c);
        mx = t[0]; mn = t[0];
        for (int i = 1; i < 3; i++) begin
            if (t[i] > mx) mx = t[i];
            if (t[i] < mn) mn = t[i];
        end
        teff = mx - mn;
        if (teff > 2 * h) teff = 2 * h;
        t0 = 2 * h - teff;
        s = t[p] + t0 / 2 - mn;
        if (s < 0) s = 0;
        if (s > 2 * h) s = 2 * h;
        return s / 2;
    endfunction

    // R8/R9: expected flags {c,b,a}
    function automatic int mid_exp(input int a, input int b, input int c);
        if ((a >= b && a <= c) || (a <= b && a >= c)) return 1;
        if ((b >= a && b <= c) || (b <= a && b >= c)) return 2;
        return 4;
    endfunction

    task automatic drive(input int i);
        half_period = CNT_W'(VH[i]);
        ref_a = REF_W'(VA[i]);
        ref_b = REF_W'(VB[i]);
        ref_c = REF_W'(VC[i]);
    endtask

    // Observe one full period of vector i; the period began at the last edge.
    task automatic run_period(input int i);
        int h;
        int w [3];
        int hi [3];
        int mis [3];
        int midv;
        h = VH[i];
        for (int p = 0; p < 3; p++) begin
            w[p] = half_w(h, VA[i], VB[i], VC[i], p);
            hi[p] = 0;
            mis[p] = 0;
        end
        midv = 0;
        for (int j = 0; j < 2 * h; j++) begin
            logic [2:0] lg;
            int c;
            @(negedge clk);
            if (j == 0) start = 1'b0;
            lg = {leg_c, leg_b, leg_a};
            c = (j < h) ? j : 2 * h - 1 - j;
            for (int p = 0; p < 3; p++) begin
                if (lg[p]) hi[p]++;
                if (lg[p] != (c >= h - w[p])) mis[p]++;
            end
            if (j == 1) midv = {mid_c, mid_b, mid_a};
            // R3: disturb inputs mid-period; R2: extra start while running
            if (j == 3) begin
                ref_a = -REF_W'(700); ref_b = REF_W'(900); ref_c = '0;
                half_period = CNT_W'(7);
            end
            if (j == 5) start = 1'b1;
            if (j == 6) start = 1'b0;
            if (j == 2 * h - 1) drive((i + 1 < NV) ? i + 1 : i);
        end
        for (int p = 0; p < 3; p++) begin
            check(hi[p] == 2 * w[p], $sformatf("R5 v%0d ph%0d high count", i, p), hi[p], 2 * w[p]);
            check(mis[p] == 0, $sformatf("R6 R3 R2 v%0d ph%0d centred pattern mismatches", i, p), mis[p], 0);
        end
        check(midv == mid_exp(VA[i], VB[i], VC[i]),
              $sformatf("R8 R9 v%0d middle flags", i), midv, mid_exp(VA[i], VB[i], VC[i]));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        drive(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle before any start
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            check({leg_a, leg_b, leg_c, mid_a, mid_b, mid_c} == 6'b0,
                  "R1 idle outputs after reset", {leg_a, leg_b, leg_c, mid_a, mid_b, mid_c}, 0);
        end
        start = 1'b1;
        for (int i = 0; i < NV; i++) run_period(i);

        // R7: overmodulated vector 2 must give phase A and C fully high, B low
        check(half_w(50, 2047, -2048, 0, 0) == 50, "R7 clamp model A", half_w(50, 2047, -2048, 0, 0), 50);

        // R1: reset mid-run returns to idle and stays there without start
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            check({leg_a, leg_b, leg_c, mid_a, mid_b, mid_c} == 6'b0,
                  "R1 idle after reset mid-run", {leg_a, leg_b, leg_c, mid_a, mid_b, mid_c}, 0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule